// File: doc/BRIEF.md
# Energy-per-instruction power throttle

This block regulates the power of a chip multiprocessor that has one large core and a set of small cores running the same instruction set. Each clock it receives one retire pulse per core. It estimates the energy spent as a sum of per-instruction costs taken from a table. That table is indexed by core type and by the current voltage/frequency level. The estimate is summed over a fixed window of cycles and compared with a programmable energy budget at the end of every window.

At each window boundary the throttle acts on the result. If the window used too much energy, it lowers the voltage/frequency level one step. Only when the level is already at its floor does it change the core mix. That change either moves the work from the large core to small cores, or switches off one small core. If the window was well under budget for two windows in a row, it gives resources back. Otherwise it follows the runnable-thread count:

- With few threads, the large core runs.
- With a moderate count, the large core runs together with a bounded number of small cores.
- With many threads, only small cores run.

A switch between the large core and the small cores emits a one-cycle migrate request. The configuration then stays frozen until the core complex acknowledges the request.

Top module: `epi_throttle`

## Requirements
- R1: Every cycle the window energy grows by the large-core table entry if the large core is enabled and retires, plus the small-core table entry for each enabled small core that retires. Both entries are taken at the current level. Entry k of a table occupies bits [16k+15:16k]. Retire pulses from disabled cores add nothing.
- R2: A window is WIN_LEN cycles long. Decisions happen only on the last cycle of a window, and the energy sum restarts from zero for the next window. Outputs never change on any other cycle.
- R3: A window is over budget when its energy is strictly greater than the budget. When an over-budget window ends at a level above 0, the level drops by exactly one and the core mix is left unchanged.
- R4: When an over-budget window ends at level 0, the core mix changes instead. If the large core is on, it is switched off. The block then enables min(max(threads,1), cap) small cores, switches to forced small-core mode and issues a migrate request. If only small cores are running, one small core is dropped, down to a minimum of one, and the cap becomes the new count.
- R5: A window is under budget when 4 × energy < 3 × budget. Two consecutive under-budget decision windows trigger one step up. The step clears forced small-core mode if it is set. Otherwise it raises the cap by one, up to the number of small cores. Otherwise it raises the level by one. Any decision window that is not under budget resets the count of consecutive windows.
- R6: On a window that is not over budget, the mix follows the thread count T, using the cap and forced mode as they were before that boundary. In forced mode only small cores run, max(T,1) of them. If T ≤ 1, only the large core runs. If 2 ≤ T ≤ 1+OVERLAP, the large core runs with T−1 small cores. Otherwise only small cores run, T of them. Every small-core count is limited to the cap. The enabled small cores are always the lowest-numbered ones.
- R7: Switching between the large core and the small cores raises migReq for exactly one cycle. Core ID 0 is the large core and ID 1 is small core 0. Going from large to small gives src 0, dst 1; going back gives src 1, dst 0. A change in the small-core count alone raises no request.
- R8: After a migrate request, level, mix, cap and hysteresis count stay unchanged until migDone is high at a clock edge. Window boundaries in that time make no decision, and so does a boundary in the same cycle as the acknowledgement.
- R9: Reset gives the highest level (NUM_LEVELS−1), the large core on, no small cores, no request, a cap equal to the number of small cores and a cleared hysteresis count.
- R10: A migDone pulse while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| largeRetire | input | 1 | Large core retired an instruction this cycle |
| smallRetire | input | NUM_SMALL | Per small core retire pulse |
| runThreads | input | TH_W | Runnable thread count |
| budget | input | ACC_W | Energy budget per window |
| epiLargeTbl | input | NUM_LEVELS×EPI_W | Large-core energy per instruction, one entry per level |
| epiSmallTbl | input | NUM_LEVELS×EPI_W | Small-core energy per instruction, one entry per level |
| migDone | input | 1 | Acknowledge of the pending migration |
| largeEn | output | 1 | Large core enabled |
| smallEn | output | NUM_SMALL | Small core enables, bit i for small core i |
| vfLevel | output | log2(NUM_LEVELS) | Voltage/frequency level, 0 lowest |
| migReq | output | 1 | One-cycle migrate request |
| migSrc | output | ID_W | Source core ID of the request |
| migDst | output | ID_W | Destination core ID of the request |

## Verification
The hardest states to reach are the floor-level actions: forced migration off the large core and the shedding of small cores one by one. Both need the level to be walked down first through several over-budget windows. The stimulus therefore holds every retire input high and lowers the budget in stages, so that each window's energy can be worked out by hand. Long acknowledge delays that span two window boundaries show that the configuration stays frozen while the thread count changes underneath. Spurious acknowledge pulses are applied in a settled state to show that they are ignored.

// File: rtl/epi_thr_pkg.sv
package epi_thr_pkg;
  // Window-boundary strobes from the energy datapath to the control.
  typedef struct packed {
    logic winEnd;
    logic over;
    logic under;
  } winStat_t;
endpackage

// File: rtl/epi_thr_energy.sv
module epi_thr_energy
  import epi_thr_pkg::*;
#(
  parameter int NUM_SMALL  = 25,
  parameter int NUM_LEVELS = 4,
  parameter int EPI_W      = 16,
  parameter int ACC_W      = 32,
  parameter int WIN_LEN    = 1024,
  localparam int VF_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        largeRetire,
  input  logic [NUM_SMALL-1:0]        smallRetire,
  input  logic                        largeOn,
  input  logic [NUM_SMALL-1:0]        smallEn,
  input  logic [VF_W-1:0]             vf,
  input  logic [NUM_LEVELS*EPI_W-1:0] epiLargeTbl,
  input  logic [NUM_LEVELS*EPI_W-1:0] epiSmallTbl,
  input  logic [ACC_W-1:0]            budget,
  output winStat_t                    stat
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int PC_W  = $clog2(NUM_SMALL + 1);

  logic [CNT_W-1:0] winCnt;
  logic [ACC_W-1:0] acc, accNext, addE;
  logic [PC_W-1:0]  activeCnt;
  logic [EPI_W-1:0] epiL, epiS;
  logic [ACC_W+1:0] scaledE, scaledB;
  logic             winEnd;

  assign epiL = epiLargeTbl[vf*EPI_W +: EPI_W];
  assign epiS = epiSmallTbl[vf*EPI_W +: EPI_W];

  // Count enabled small cores that retired this cycle.
  always_comb begin
    activeCnt = '0;
    for (int i = 0; i < NUM_SMALL; i++)
      activeCnt = activeCnt + PC_W'(smallRetire[i] & smallEn[i]);
  end

  assign addE    = ((largeRetire && largeOn) ? ACC_W'(epiL) : '0)
                 + ACC_W'(activeCnt) * ACC_W'(epiS);
  assign accNext = acc + addE;
  assign winEnd  = (winCnt == CNT_W'(WIN_LEN - 1));
  assign scaledE = {accNext, 2'b00};
  assign scaledB = {2'b00, budget} + {1'b0, budget, 1'b0};

  assign stat.winEnd = winEnd;
  assign stat.over   = winEnd && (accNext > budget);
  assign stat.under  = winEnd && (scaledE < scaledB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      acc    <= '0;
    end else if (winEnd) begin
      winCnt <= '0;
      acc    <= '0;
    end else begin
      winCnt <= winCnt + CNT_W'(1);
      acc    <= accNext;
    end
  end

  a_r2_acc_clear: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |=> acc == '0);
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> winCnt == $past(winCnt) + CNT_W'(1));
  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> acc >= $past(acc));
endmodule

// File: rtl/epi_thr_control.sv
module epi_thr_control
  import epi_thr_pkg::*;
#(
  parameter int NUM_SMALL  = 25,
  parameter int NUM_LEVELS = 4,
  parameter int OVERLAP    = 5,
  parameter int TH_W       = 6,
  parameter int ID_W       = 5,
  localparam int VF_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int SC_W      = $clog2(NUM_SMALL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  winStat_t        stat,
  input  logic [TH_W-1:0] runThreads,
  input  logic            migDone,
  output logic [VF_W-1:0] vf,
  output logic            largeOn,
  output logic [SC_W-1:0] nSmall,
  output logic            migReq,
  output logic [ID_W-1:0] migSrc,
  output logic [ID_W-1:0] migDst
);
  localparam logic [VF_W-1:0] TOP_VF   = VF_W'(NUM_LEVELS - 1);
  localparam logic [ID_W-1:0] LARGE_ID = '0;
  localparam logic [ID_W-1:0] SMALL0_ID = ID_W'(1);

  logic [SC_W-1:0] cap, tgtSmall, shedSmall;
  logic            forceSmall, streak, busy, tgtLarge;

  // Target mix from thread count, cap and forced mode (pre-boundary values).
  always_comb begin
    int t, c, s, h;
    t = int'(runThreads);
    c = int'(cap);
    h = (t < 1) ? 1 : t;
    if (forceSmall) begin
      tgtLarge = 1'b0; s = h;
    end else if (t <= 1) begin
      tgtLarge = 1'b1; s = 0;
    end else if (t <= 1 + OVERLAP) begin
      tgtLarge = 1'b1; s = t - 1;
    end else begin
      tgtLarge = 1'b0; s = t;
    end
    if (s > c) s = c;
    if (h > c) h = c;
    tgtSmall  = SC_W'(s);
    shedSmall = SC_W'(h);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vf         <= TOP_VF;
      largeOn    <= 1'b1;
      nSmall     <= '0;
      cap        <= SC_W'(NUM_SMALL);
      forceSmall <= 1'b0;
      streak     <= 1'b0;
      busy       <= 1'b0;
      migReq     <= 1'b0;
      migSrc     <= '0;
      migDst     <= '0;
    end else begin
      migReq <= 1'b0;
      if (busy && migDone) busy <= 1'b0;
      if (stat.winEnd && !busy) begin
        if (stat.over) begin
          streak <= 1'b0;
          if (vf != '0) begin
            vf <= vf - VF_W'(1);
          end else if (largeOn) begin
            forceSmall <= 1'b1;
            largeOn    <= 1'b0;
            nSmall     <= shedSmall;
            migReq     <= 1'b1;
            migSrc     <= LARGE_ID;
            migDst     <= SMALL0_ID;
            busy       <= 1'b1;
          end else if (nSmall > SC_W'(1)) begin
            nSmall <= nSmall - SC_W'(1);
            cap    <= nSmall - SC_W'(1);
          end
        end else begin
          if (stat.under) begin
            if (streak) begin
              streak <= 1'b0;
              if (forceSmall)                 forceSmall <= 1'b0;
              else if (cap < SC_W'(NUM_SMALL)) cap       <= cap + SC_W'(1);
              else if (vf != TOP_VF)           vf        <= vf + VF_W'(1);
            end else begin
              streak <= 1'b1;
            end
          end else begin
            streak <= 1'b0;
          end
          if (tgtLarge != largeOn) begin
            migReq <= 1'b1;
            migSrc <= largeOn ? LARGE_ID : SMALL0_ID;
            migDst <= largeOn ? SMALL0_ID : LARGE_ID;
            busy   <= 1'b1;
          end
          largeOn <= tgtLarge;
          nSmall  <= tgtSmall;
        end
      end
    end
  end

  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    migReq |=> !migReq);
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !migDone) |=> ($stable(vf) && $stable(largeOn) && $stable(nSmall) && !migReq));
  a_r3_level_first: assert property (@(posedge clk) disable iff (!rstN)
    (stat.winEnd && stat.over && !busy && vf != '0)
      |=> (vf == $past(vf) - VF_W'(1)) && $stable(largeOn) && $stable(nSmall));
  a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    !stat.winEnd |=> ($stable(vf) && $stable(largeOn) && $stable(nSmall)));
  a_r6_overlap_bound: assert property (@(posedge clk) disable iff (!rstN)
    largeOn |-> nSmall <= SC_W'(OVERLAP));
  a_r6_small_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    !largeOn |-> nSmall != '0);
endmodule

// File: rtl/epi_throttle.sv
module epi_throttle
  import epi_thr_pkg::*;
#(
  parameter int NUM_SMALL  = 25,
  parameter int NUM_LEVELS = 4,
  parameter int EPI_W      = 16,
  parameter int ACC_W      = 32,
  parameter int WIN_LEN    = 1024,
  parameter int OVERLAP    = 5,
  parameter int TH_W       = 6,
  parameter int ID_W       = 5,
  localparam int VF_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        largeRetire,
  input  logic [NUM_SMALL-1:0]        smallRetire,
  input  logic [TH_W-1:0]             runThreads,
  input  logic [ACC_W-1:0]            budget,
  input  logic [NUM_LEVELS*EPI_W-1:0] epiLargeTbl,
  input  logic [NUM_LEVELS*EPI_W-1:0] epiSmallTbl,
  input  logic                        migDone,
  output logic                        largeEn,
  output logic [NUM_SMALL-1:0]        smallEn,
  output logic [VF_W-1:0]             vfLevel,
  output logic                        migReq,
  output logic [ID_W-1:0]             migSrc,
  output logic [ID_W-1:0]             migDst
);
  localparam int SC_W = $clog2(NUM_SMALL + 1);

  winStat_t        stat;
  logic [SC_W-1:0] nSmall;
  logic            largeOn;
  logic [VF_W-1:0] vf;

  // Thermometer enable: the lowest nSmall small cores run.
  for (genvar i = 0; i < NUM_SMALL; i++) begin : g_en
    assign smallEn[i] = (SC_W'(i) < nSmall);
  end

  assign largeEn = largeOn;
  assign vfLevel = vf;

  epi_thr_energy #(
    .NUM_SMALL(NUM_SMALL), .NUM_LEVELS(NUM_LEVELS), .EPI_W(EPI_W),
    .ACC_W(ACC_W), .WIN_LEN(WIN_LEN)
  ) u_energy (
    .clk(clk), .rstN(rstN), .largeRetire(largeRetire), .smallRetire(smallRetire),
    .largeOn(largeOn), .smallEn(smallEn), .vf(vf),
    .epiLargeTbl(epiLargeTbl), .epiSmallTbl(epiSmallTbl),
    .budget(budget), .stat(stat)
  );

  epi_thr_control #(
    .NUM_SMALL(NUM_SMALL), .NUM_LEVELS(NUM_LEVELS), .OVERLAP(OVERLAP),
    .TH_W(TH_W), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .runThreads(runThreads),
    .migDone(migDone), .vf(vf), .largeOn(largeOn), .nSmall(nSmall),
    .migReq(migReq), .migSrc(migSrc), .migDst(migDst)
  );
endmodule

// File: tb/tb_epi_throttle.sv
module tb_epi_throttle;
  localparam int NS  = 25;
  localparam int NL  = 4;
  localparam int WIN = 32;
  localparam int OVL = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          largeRetire = 1'b0;
  logic [NS-1:0] smallRetire = '0;
  logic [5:0]    runThreads = 6'd1;
  logic [31:0]   budget = 32'd6000;
  logic [63:0]   epiLargeTbl, epiSmallTbl;
  logic          migDone = 1'b0;
  logic          largeEn;
  logic [NS-1:0] smallEn;
  logic [1:0]    vfLevel;
  logic          migReq;
  logic [4:0]    migSrc, migDst;

  int epiL[NL] = '{100, 160, 250, 400};
  int epiS[NL] = '{4, 7, 10, 16};

  int nChecks = 0, nFails = 0;
  int largeRate = 256, smallRate = 256, ackDelay = 3, ackCnt = 0, cyc = 0;
  bit spurious = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  // reference model state
  int mVf = 3, mLarge = 1, mNs = 0, mCap = NS, mForce = 0, mStreak = 0, mBusy = 0;
  int mMigReq = 0, mSrc = 0, mDst = 0, mAcc = 0, mCnt = 0;
  int add, tot, oldBusy, t, s, oc, ofc, tl;

  always #4 clk = ~clk;

  epi_throttle #(.NUM_SMALL(NS), .NUM_LEVELS(NL), .WIN_LEN(WIN), .OVERLAP(OVL)) dut (
    .clk(clk), .rstN(rstN), .largeRetire(largeRetire), .smallRetire(smallRetire),
    .runThreads(runThreads), .budget(budget), .epiLargeTbl(epiLargeTbl),
    .epiSmallTbl(epiSmallTbl), .migDone(migDone), .largeEn(largeEn), .smallEn(smallEn),
    .vfLevel(vfLevel), .migReq(migReq), .migSrc(migSrc), .migDst(migDst));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mig(input int src, input int dst);
    mMigReq = 1; mSrc = src; mDst = dst; mBusy = 1;
  endtask

  // Boundary decision of the reference model (R3..R7).
  task automatic decide(input int e);
    t = int'(runThreads);
    if (e > int'(budget)) begin
      mStreak = 0;
      if (mVf > 0) mVf--;
      else if (mLarge == 1) begin
        s = (t < 1) ? 1 : t; if (s > mCap) s = mCap;
        mForce = 1; mLarge = 0; mNs = s; mig(0, 1);
      end else if (mNs > 1) begin
        mNs--; mCap = mNs;
      end
    end else begin
      oc = mCap; ofc = mForce;
      if (4 * e < 3 * int'(budget)) begin
        if (mStreak == 1) begin
          mStreak = 0;
          if (mForce == 1) mForce = 0;
          else if (mCap < NS) mCap++;
          else if (mVf < NL - 1) mVf++;
        end else mStreak = 1;
      end else mStreak = 0;
      if (ofc == 1) begin tl = 0; s = (t < 1) ? 1 : t; end
      else if (t <= 1) begin tl = 1; s = 0; end
      else if (t <= 1 + OVL) begin tl = 1; s = t - 1; end
      else begin tl = 0; s = t; end
      if (s > oc) s = oc;
      if (tl != mLarge) mig(mLarge == 1 ? 0 : 1, mLarge == 1 ? 1 : 0);
      mLarge = tl; mNs = s;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mVf = NL - 1; mLarge = 1; mNs = 0; mCap = NS; mForce = 0; mStreak = 0;
      mBusy = 0; mMigReq = 0; mAcc = 0; mCnt = 0;
    end else begin
      add = 0;
      if (mLarge == 1 && largeRetire) add += epiL[mVf];
      for (int i = 0; i < NS; i++) if (i < mNs && smallRetire[i]) add += epiS[mVf];
      tot = mAcc + add; oldBusy = mBusy; mMigReq = 0;
      if (mBusy == 1 && migDone) mBusy = 0;
      if (mCnt == WIN - 1) begin
        mCnt = 0; mAcc = 0;
        if (oldBusy == 0) decide(tot);
      end else begin
        mCnt++; mAcc = tot;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      logic [NS-1:0] expEn;
      for (int i = 0; i < NS; i++) expEn[i] = (i < mNs);
      check(int'(vfLevel) == mVf, "R2 R3 R5 level", int'(vfLevel), mVf);
      check(int'(largeEn) == mLarge, "R4 R6 large enable", int'(largeEn), mLarge);
      check(smallEn == expEn, "R6 small enables", int'(smallEn), int'(expEn));
      check(int'(migReq) == mMigReq, "R7 R8 migrate request", int'(migReq), mMigReq);
      if (mMigReq == 1) begin
        check(int'(migSrc) == mSrc, "R7 migrate source", int'(migSrc), mSrc);
        check(int'(migDst) == mDst, "R7 migrate destination", int'(migDst), mDst);
      end
    end
  end

  // Retire pulses and acknowledge responder.
  always @(negedge clk) begin
    cyc++;
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    largeRetire = (int'(lfsr[7:0]) < largeRate);
    for (int i = 0; i < NS; i++)
      smallRetire[i] = (int'(lfsr[(i % 24) +: 8] ^ 8'(i * 37)) < smallRate);
    migDone = 1'b0;
    if (migReq) ackCnt = ackDelay;
    else if (ackCnt > 0) begin
      ackCnt--;
      if (ackCnt == 0) migDone = 1'b1;
    end
    if (spurious && ackCnt == 0 && (cyc % 7 == 0)) migDone = 1'b1;
  end

  task automatic waitWin(input int n);
    repeat (n * WIN) @(negedge clk);
  endtask

  initial begin
    int nMig;
    int firstSrc, firstDst;
    for (int k = 0; k < NL; k++) begin
      epiLargeTbl[k*16 +: 16] = 16'(epiL[k]);
      epiSmallTbl[k*16 +: 16] = 16'(epiS[k]);
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(vfLevel == 2'd3, "R9 reset level", int'(vfLevel), 3);
    check(largeEn == 1'b1, "R9 reset large", int'(largeEn), 1);
    check(smallEn == '0, "R9 reset small", int'(smallEn), 0);
    check(migReq == 1'b0, "R9 reset request", int'(migReq), 0);
    rstN = 1'b1;

    // R1/R3: large alone, disabled small cores pulsing; 12800 -> 8000 -> 5120
    waitWin(6);
    check(vfLevel == 2'd1, "R3 level after two over windows", int'(vfLevel), 1);
    check(smallEn == '0, "R1 disabled pulses ignored", int'(smallEn), 0);

    // R4/R7: floor reached, large core forced off
    budget = 32'd3000; nMig = 0; firstSrc = -1; firstDst = -1;
    repeat (12 * WIN) begin
      @(negedge clk);
      if (migReq) begin
        if (nMig == 0) begin firstSrc = int'(migSrc); firstDst = int'(migDst); end
        nMig++;
      end
    end
    check(nMig > 0, "R4 forced migration seen", nMig, 1);
    check(firstSrc == 0, "R7 first source is large", firstSrc, 0);
    check(firstDst == 1, "R7 first destination is small 0", firstDst, 1);

    // R5/R6: generous budget, overlap of large and three small cores
    budget = 32'd100000; runThreads = 6'd4;
    waitWin(25);
    check(vfLevel == 2'd3, "R5 level restored", int'(vfLevel), 3);
    check(largeEn == 1'b1, "R6 overlap large", int'(largeEn), 1);
    check(smallEn == 25'h7, "R6 overlap small", int'(smallEn), 7);

    // R10: spurious acknowledge
    spurious = 1'b1; waitWin(5); spurious = 1'b0;
    check(smallEn == 25'h7 && largeEn, "R10 spurious ack ignored", int'(smallEn), 7);

    // R8: slow acknowledge spanning two boundaries
    ackDelay = 80; runThreads = 6'd20;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (migReq) break;
    end
    runThreads = 6'd40;
    repeat (70) @(negedge clk);
    check($countones(smallEn) == 20, "R8 frozen while pending", $countones(smallEn), 20);
    check(largeEn == 1'b0, "R8 large off while pending", int'(largeEn), 0);
    waitWin(4);
    check($countones(smallEn) == 25, "R6 small-only at cap", $countones(smallEn), 25);

    // R4: shed small cores at level 0 down to 15 (15*4*32 = 1920 <= 2000)
    ackDelay = 3; budget = 32'd2000;
    waitWin(20);
    check(vfLevel == 2'd0, "R4 level floor", int'(vfLevel), 0);
    check($countones(smallEn) == 15, "R4 shed count", $countones(smallEn), 15);

    // R5: two under windows raise cap to 16, then 2048 is not under
    budget = 32'd2600;
    waitWin(8);
    check($countones(smallEn) == 16, "R5 cap step up", $countones(smallEn), 16);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule